// File: doc/BRIEF.md
# Three-Operand Lane-Split ALU

This block is a 32-bit ALU that combines three source words, A, B and C, in one operation and registers the outcome. A 9-bit operation code selects one of two modes. In the logic mode the low byte of the code is an 8-entry truth table. That table is evaluated bit by bit over the triple (A, B, C), so any of the 256 three-input bitwise functions can be produced. In the add mode, A is summed with an addend built bitwise from B and C by a 4-entry table, plus an optional carry of one. This lets C mask or steer B before the add, for example B AND C, or NOT B with carry for a subtract.

The adder can be cut into two halfword lanes or four byte lanes, so that no carry crosses a lane boundary. Each lane can wrap, or clamp to its own unsigned or signed limits when it overflows. The block reports the carry out of each lane and a zero flag. All outputs are registered and appear one cycle after an input marked valid.

Top module: `alu3_core`

## Requirements
- R1: With op_code[8]=0, result bit i equals op_code[7:0] indexed by {A[i],B[i],C[i]}, with A as the most significant index bit.
- R2: With op_code[8]=1, every addend bit X[i] is op_code[3:0] indexed by {B[i],C[i]}, with B as the most significant index bit. Each lane result is then A + X + op_code[4], taken modulo the lane size, and op_code[4] is added into every lane.
- R3: lane_sel 00 gives one 32-bit lane, 01 gives two 16-bit lanes, and 10 or 11 gives four 8-bit lanes. No carry crosses a lane boundary.
- R4: carry_out[k] is the carry out of lane k, where lane 0 holds the least significant bits. Bits with no lane behind them read 0, and all of carry_out is 0 in logic mode.
- R5: With op_code[5]=1 and op_code[6]=0, any lane whose unsigned sum exceeds the lane maximum reads all ones.
- R6: With op_code[5]=1 and op_code[6]=1, any lane whose signed sum leaves the lane range reads its signed maximum (0111..) or signed minimum (1000..).
- R7: op_code[7] has no effect in add mode, and op_code[6] has no effect on result when op_code[5]=0.
- R8: zero is 1 exactly when the registered result is all zeros.
- R9: out_valid follows in_valid one cycle later. The outputs are loaded only when in_valid=1 and hold their values otherwise.
- R10: While rst_n=0, result and carry_out read 0, zero reads 1 and out_valid reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_c | input | 32 | Operand C (mask / third input) |
| op_code | input | 9 | [8] mode, [7:0] truth table or {[6] signed,[5] saturate,[4] carry,[3:0] addend table} |
| lane_sel | input | 2 | Lane size select |
| out_valid | output | 1 | Registered outputs are new |
| result | output | 32 | Registered result |
| carry_out | output | 4 | Per-lane carry out |
| zero | output | 1 | Result is zero |

## Verification
The hardest situation to reach is saturation in a lane that holds overflow while its neighbour does not. Signed overflow in the top byte of a 16-bit lane, made with a carry-in of one, is an example. Random operands seldom land exactly on a lane limit. For that reason the stimulus biases random operands toward 0x00, 0x7F, 0x80 and 0xFF per byte, and it adds directed cases that place each limit in one lane only, under every lane split.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 4;
  localparam int unsigned DATA_W  = BYTE_W * N_BYTES;
  localparam int unsigned OP_W    = 9;

  typedef enum logic [1:0] {
    LANE_W32 = 2'b00,
    LANE_W16 = 2'b01,
    LANE_W8  = 2'b10,
    LANE_W8B = 2'b11
  } lane_e;

  // bitwise three-input truth table, index {a,b,c}
  function automatic logic [DATA_W-1:0] tt3(input logic [7:0] f,
      input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] c);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = f[{a[i], b[i], c[i]}];
    return r;
  endfunction

  // bitwise two-input truth table, index {b,c}
  function automatic logic [DATA_W-1:0] tt2(input logic [3:0] g,
      input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] c);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = g[{b[i], c[i]}];
    return r;
  endfunction

  // byte k begins a new lane
  function automatic logic lane_start(input logic [1:0] m, input int k);
    return (k == 0) || m[1] || ((m == LANE_W16) && (k == 2));
  endfunction

  // index of the most significant byte of the lane that owns byte k
  function automatic logic [1:0] lane_top(input logic [1:0] m, input logic [1:0] k);
    if (m[1]) return k;
    if (m == LANE_W16) return k | 2'b01;
    return 2'b11;
  endfunction
endpackage

// File: rtl/alu3_tt_unit.sv
module alu3_tt_unit
  import alu3_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  input  logic [OP_W-1:0]   code,
  output logic [DATA_W-1:0] logic_out,
  output logic [DATA_W-1:0] addend
);
  assign logic_out = tt3(code[7:0], a, b, c);
  assign addend    = tt2(code[3:0], b, c);
endmodule

// File: rtl/alu3_split_add.sv
module alu3_split_add
  import alu3_pkg::*;
(
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  x,
  input  logic               cin,
  input  logic [1:0]         lane_sel,
  output logic [DATA_W-1:0]  sum,
  output logic [N_BYTES-1:0] byte_co,
  output logic [N_BYTES-1:0] byte_c7
);
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    logic ci;
    logic [BYTE_W:0] full;
    logic [BYTE_W-1:0] low;
    if (k == 0) begin : g_first
      assign ci = cin;
    end else begin : g_next
      assign ci = lane_start(lane_sel, k) ? cin : g_byte[k-1].full[BYTE_W];
    end
    assign full = {1'b0, a[BYTE_W*k +: BYTE_W]} + {1'b0, x[BYTE_W*k +: BYTE_W]}
                  + {{BYTE_W{1'b0}}, ci};
    assign low  = {1'b0, a[BYTE_W*k +: BYTE_W-1]} + {1'b0, x[BYTE_W*k +: BYTE_W-1]}
                  + {{(BYTE_W-1){1'b0}}, ci};
    assign sum[BYTE_W*k +: BYTE_W] = full[BYTE_W-1:0];
    assign byte_co[k] = full[BYTE_W];
    assign byte_c7[k] = low[BYTE_W-1];
  end
endmodule

// File: rtl/alu3_lane_sat.sv
module alu3_lane_sat
  import alu3_pkg::*;
(
  input  logic [DATA_W-1:0]  sum,
  input  logic [N_BYTES-1:0] byte_co,
  input  logic [N_BYTES-1:0] byte_c7,
  input  logic [1:0]         lane_sel,
  input  logic               sat_en,
  input  logic               sgn,
  output logic [DATA_W-1:0]  sat_out,
  output logic [N_BYTES-1:0] byte_ovf
);
  always_comb begin
    sat_out  = sum;
    byte_ovf = '0;
    for (int k = 0; k < N_BYTES; k++) begin
      logic [1:0] m;
      logic pos;
      m = lane_top(lane_sel, 2'(k));
      byte_ovf[k] = sgn ? (byte_c7[m] ^ byte_co[m]) : byte_co[m];
      pos = sum[BYTE_W*m + BYTE_W-1];
      if (sat_en && byte_ovf[k]) begin
        if (!sgn) begin
          sat_out[BYTE_W*k +: BYTE_W] = '1;
        end else if (pos) begin
          sat_out[BYTE_W*k +: BYTE_W] = (2'(k) == m) ? 8'h7F : 8'hFF;
        end else begin
          sat_out[BYTE_W*k +: BYTE_W] = (2'(k) == m) ? 8'h80 : 8'h00;
        end
      end
    end
  end
endmodule

// File: rtl/alu3_core.sv
module alu3_core
  import alu3_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  op_a,
  input  logic [31:0]  op_b,
  input  logic [31:0]  op_c,
  input  logic [8:0]   op_code,
  input  logic [1:0]   lane_sel,
  output logic         out_valid,
  output logic [31:0]  result,
  output logic [3:0]   carry_out,
  output logic         zero
);
  logic [DATA_W-1:0]  logic_out, addend, sum, sat_out, next_res;
  logic [N_BYTES-1:0] byte_co, byte_c7, byte_ovf, lane_co;
  logic               arith_mode;

  assign arith_mode = op_code[8];

  alu3_tt_unit u_tt (
    .a(op_a), .b(op_b), .c(op_c), .code(op_code),
    .logic_out(logic_out), .addend(addend)
  );

  alu3_split_add u_add (
    .a(op_a), .x(addend), .cin(op_code[4]), .lane_sel(lane_sel),
    .sum(sum), .byte_co(byte_co), .byte_c7(byte_c7)
  );

  alu3_lane_sat u_sat (
    .sum(sum), .byte_co(byte_co), .byte_c7(byte_c7), .lane_sel(lane_sel),
    .sat_en(op_code[5]), .sgn(op_code[6]),
    .sat_out(sat_out), .byte_ovf(byte_ovf)
  );

  always_comb begin
    case (lane_sel)
      LANE_W32: lane_co = {3'b000, byte_co[3]};
      LANE_W16: lane_co = {2'b00, byte_co[3], byte_co[1]};
      default:  lane_co = byte_co;
    endcase
    if (!arith_mode) lane_co = '0;
  end

  assign next_res = arith_mode ? sat_out : logic_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= '0;
      zero      <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= next_res;
        carry_out <= lane_co;
        zero      <= (next_res == '0);
      end
    end
  end
endmodule

// File: rtl/alu3_chk.sv
module alu3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [8:0]  op_code,
  input logic [1:0]  lane_sel,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [3:0]  carry_out,
  input logic        zero
);
  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(zero)));
  // R4
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_code[8]) |=> carry_out == 4'b0);
  // R4
  wide_lane_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code[8] && lane_sel == 2'b00) |=> carry_out[3:1] == 3'b0);
  // R4
  half_lane_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code[8] && lane_sel == 2'b01) |=> carry_out[3:2] == 2'b0);
  // R1
  pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 9'h0F0) |=> result == $past(op_a));
  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero == (result == 32'h0)));
endmodule

bind alu3_core alu3_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
  .op_code(op_code), .lane_sel(lane_sel), .out_valid(out_valid),
  .result(result), .carry_out(carry_out), .zero(zero)
);

// File: tb/alu3_core_tb_top.sv
`timescale 1ns/1ps
module alu3_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic [8:0]  op_code = '0;
  logic [1:0]  lane_sel = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  carry_out;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  alu3_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .op_code(op_code), .lane_sel(lane_sel), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .zero(zero)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lane-by-lane reference in wide integers
  function automatic void model(input logic [31:0] a, b, c, input logic [8:0] op,
      input logic [1:0] ls, output logic [31:0] r, output logic [3:0] co);
    int w, n;
    longint ua, ux, s, msk, half, sa, sx, ss, lr;
    logic [31:0] x;
    r = '0; co = '0;
    if (!op[8]) begin
      for (int i = 0; i < 32; i++) r[i] = op[{a[i], b[i], c[i]}];
      return;
    end
    for (int i = 0; i < 32; i++) x[i] = op[{b[i], c[i]}];
    w = ls[1] ? 8 : (ls == 2'b01 ? 16 : 32);
    n = 32 / w;
    msk = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    for (int l = 0; l < n; l++) begin
      ua = (longint'(a) >> (l * w)) & msk;
      ux = (longint'(x) >> (l * w)) & msk;
      s  = ua + ux + longint'(op[4]);
      co[l] = s[w];
      lr = s & msk;
      if (op[5]) begin
        if (op[6]) begin
          sa = (ua >= half) ? ua - 2 * half : ua;
          sx = (ux >= half) ? ux - 2 * half : ux;
          ss = sa + sx + longint'(op[4]);
          if (ss > half - 1) lr = half - 1;
          else if (ss < -half) lr = half;
        end else if (s > msk) begin
          lr = msk;
        end
      end
      r = r | 32'(lr << (l * w));
    end
  endfunction

  function automatic string res_tag(input logic [8:0] op, input logic [1:0] ls);
    if (!op[8]) return "R1";
    if (op[5] && op[6]) return "R6";
    if (op[5]) return "R5";
    if (ls != 2'b00) return "R3";
    return "R2";
  endfunction

  logic [31:0] last_r;

  task automatic run(input logic [31:0] a, b, c, input logic [8:0] op,
      input logic [1:0] ls, input string tag);
    logic [31:0] er;
    logic [3:0]  ec;
    model(a, b, c, op, ls, er, ec);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; op_code = op; lane_sel = ls; in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " result"}, result, er);
    chk("R4 carry", {28'b0, carry_out}, {28'b0, ec});
    chk("R8 zero", {31'b0, zero}, {31'b0, (er == 32'h0)});
    chk("R9 valid", {31'b0, out_valid}, 32'h1);
    last_r = er;
  endtask

  function automatic logic [31:0] edgy();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      case ($urandom % 6)
        0: v[8*k +: 8] = 8'h00;
        1: v[8*k +: 8] = 8'h7F;
        2: v[8*k +: 8] = 8'h80;
        3: v[8*k +: 8] = 8'hFF;
        default: v[8*k +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [8:0] op;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 result", result, 32'h0);
    chk("R10 carry", {28'b0, carry_out}, 32'h0);
    chk("R10 zero", {31'b0, zero}, 32'h1);
    chk("R10 valid", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;

    // R1 logic mode directed
    run(32'hF0F0_1234, 32'hCCCC_5678, 32'hAAAA_9ABC, 9'h096, 2'b00, "R1");
    run(32'h1234_5678, 32'h0, 32'h0, 9'h0F0, 2'b00, "R1");
    run(32'hDEAD_BEEF, 32'h1, 32'h2, 9'h000, 2'b00, "R1");
    // R2 plain add, subtract (X=~B, carry 1), masked add (X=B&C)
    run(32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 9'h10C, 2'b00, "R2");
    run(32'h0000_0005, 32'h0000_0007, 32'h0, 9'h113, 2'b00, "R2");
    run(32'h1000_0000, 32'hFFFF_FFFF, 32'h00FF_00FF, 9'h108, 2'b00, "R2");
    // R3 carry stops at lane boundaries
    run(32'h00FF_00FF, 32'h0000_0101, 32'h0, 9'h10C, 2'b10, "R3");
    run(32'h00FF_00FF, 32'h0000_0101, 32'h0, 9'h10C, 2'b11, "R3");
    run(32'hFFFF_FFFF, 32'h0001_0001, 32'h0, 9'h10C, 2'b01, "R3");
    // R5 unsigned clamp in one byte lane only
    run(32'h10FF_2030, 32'h0001_0101, 32'h0, 9'h12C, 2'b10, "R5");
    run(32'hFFFF_0000, 32'h0001_0000, 32'h0, 9'h12C, 2'b00, "R5");
    // R6 signed clamp in one lane, both directions, with carry-in
    run(32'h7F00_0000, 32'h0100_0000, 32'h0, 9'h16C, 2'b10, "R6");
    run(32'h0080_7FFF, 32'h00FF_0000, 32'h0, 9'h17C, 2'b01, "R6");
    run(32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 9'h173, 2'b00, "R6");
    // R7 ignored bits: op[7] in add mode, op[6] without saturation
    run(32'h7F7F_7F7F, 32'h0101_0101, 32'h0, 9'h18C, 2'b10, "R7");
    run(32'h7F7F_7F7F, 32'h0101_0101, 32'h0, 9'h14C, 2'b10, "R7");
    // R8 zero from an add
    run(32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 9'h10C, 2'b00, "R8");

    // R9 hold while in_valid is low
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h1357_9BDF; op_code = 9'h0F0;
    @(negedge clk);
    chk("R9 hold valid", {31'b0, out_valid}, 32'h0);
    chk("R9 hold result", result, last_r);

    for (int i = 0; i < 400; i++) begin
      op = 9'($urandom);
      run(edgy(), edgy(), 32'($urandom), op, 2'($urandom), res_tag(op, lane_sel));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule